// File: doc/BRIEF.md
# CRC-5 Framed Pulse Serializer

The block turns one sensor reading into a framed serial stream for an inductive on-off transmitter. A single-cycle start strobe loads four inputs at once: a 14-bit pressure word, a 2-bit channel number, 16 parity bits produced by an upstream error-correction coder, and the 2-bit chip address. The block then sends a frame of 46 bits. The frame has a run of four ones, then 20 data bits, then the 16 parity bits, then a 5-bit CRC that is built while the payload goes out, and last a single stop one.

Each bit occupies one bit period. A one is sent as one narrow pulse at the start of its period. A zero leaves the output low for the whole period. The chip address selects the bit period, so several chips sharing one receiver produce streams at different rates. All durations are counted in ticks of a time-base enable. The pulse width and the four bit periods are parameters, so a fast reference clock can meet a 1 µs pulse while the bit periods stay in the sub-millisecond range.

Top module: `crc5_pulse_framer`

## Requirements
- R1: After reset, busy_o, done_o and pulse_o are low.
- R2: The frame is sent as 46 bits in this order: four ones, then the 20 data bits, then parity_i[0] to parity_i[15], then the 5 CRC bits, then one stop bit of value 1.
- R3: The 20 data bits go out in this order: addr[0], addr[1], pressure[0] to pressure[13], channel[0], channel[1], addr[0], addr[1]. The address is the value sampled with the start strobe.
- R4: The CRC uses the generator x^5+x^2+1 and starts from 00000. It covers the 20 data bits and the 16 parity bits in sending order and no other bits. Its bit 4 is sent first.
- R5: A one bit drives pulse_o high for the first PULSE_TICKS ticks of its bit period. A zero bit keeps pulse_o low for the whole period.
- R6: The bit period is BIT_TICKS_A0, A1, A2 or A3 ticks for sampled address 0, 1, 2 or 3.
- R7: Counting advances only on cycles with tick_en high. With tick_en low, the output holds its state.
- R8: busy_o rises in the cycle after an accepted start strobe. It falls when the stop bit's period ends, and done_o is high for exactly that one cycle.
- R9: A start strobe that arrives while busy_o is high is ignored. The frame in progress goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base enable; one tick per high cycle |
| start_i | input | 1 | Load strobe; starts a frame when idle |
| pressure_i | input | 14 | Pressure word |
| channel_i | input | 2 | Sensor channel number |
| parity_i | input | 16 | Error-correction parity bits |
| addr_i | input | 2 | Chip address; selects the bit period and is sent in the frame |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-cycle strobe when the stop bit ends |
| pulse_o | output | 1 | Narrow-pulse transmit output |

## Verification
The bench builds the block with a pulse width of 2 ticks and bit periods of 8, 6, 5 and 4 ticks. With these values a whole 46-bit frame lasts only a few hundred cycles. That makes it practical to compare every output cycle of several frames, one for each address, against a frame and CRC that the bench builds from the requirements. The short frames also leave room for a run with tick_en at half rate and for a start strobe injected in the middle of a frame.

// File: rtl/crc5_pulse_framer.sv
module crc5_pulse_framer #(
  parameter int PULSE_TICKS  = 125,
  parameter int BIT_TICKS_A0 = 41250,
  parameter int BIT_TICKS_A1 = 31250,
  parameter int BIT_TICKS_A2 = 25000,
  parameter int BIT_TICKS_A3 = 17500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        start_i,
  input  logic [13:0] pressure_i,
  input  logic [1:0]  channel_i,
  input  logic [15:0] parity_i,
  input  logic [1:0]  addr_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        pulse_o
);
  localparam int HEAD_BITS  = 4;
  localparam int DATA_BITS  = 20;
  localparam int PAR_BITS   = 16;
  localparam int CRC_BITS   = 5;
  localparam int FRAME_BITS = HEAD_BITS + DATA_BITS + PAR_BITS + CRC_BITS + 1;
  localparam int PAR_FIRST  = HEAD_BITS + DATA_BITS;
  localparam int CRC_FIRST  = PAR_FIRST + PAR_BITS;
  localparam int LAST_BIT   = FRAME_BITS - 1;
  localparam int IW         = $clog2(FRAME_BITS);
  localparam int MAX_A01    = (BIT_TICKS_A0 > BIT_TICKS_A1) ? BIT_TICKS_A0 : BIT_TICKS_A1;
  localparam int MAX_A23    = (BIT_TICKS_A2 > BIT_TICKS_A3) ? BIT_TICKS_A2 : BIT_TICKS_A3;
  localparam int MAX_TICKS  = (MAX_A01 > MAX_A23) ? MAX_A01 : MAX_A23;
  localparam int CW         = $clog2(MAX_TICKS + 1);
  localparam logic [CRC_BITS-1:0] POLY = 5'b00101;

  logic [DATA_BITS-1:0] dat_q;
  logic [PAR_BITS-1:0]  par_q;
  logic [1:0]           adr_q;
  logic [CRC_BITS-1:0]  crc_q;
  logic [IW-1:0]        idx_q;
  logic [CW-1:0]        cnt_q;
  logic                 busy_q, done_q;
  logic [CW-1:0]        period;
  logic                 cur_bit;

  wire [DATA_BITS-1:0] dat_w = {addr_i, channel_i, pressure_i, addr_i};
  wire accept   = start_i && !busy_q;
  wire bit_end  = busy_q && tick_en && (cnt_q == period - 1'b1);
  wire in_pay   = (idx_q >= IW'(HEAD_BITS)) && (idx_q < IW'(CRC_FIRST));
  wire crc_fb   = crc_q[CRC_BITS-1] ^ cur_bit;

  always_comb begin
    case (adr_q)
      2'd0:    period = CW'(BIT_TICKS_A0);
      2'd1:    period = CW'(BIT_TICKS_A1);
      2'd2:    period = CW'(BIT_TICKS_A2);
      default: period = CW'(BIT_TICKS_A3);
    endcase
  end

  always_comb begin
    if (idx_q < IW'(HEAD_BITS))
      cur_bit = 1'b1;
    else if (idx_q < IW'(PAR_FIRST))
      cur_bit = dat_q[idx_q - IW'(HEAD_BITS)];
    else if (idx_q < IW'(CRC_FIRST))
      cur_bit = par_q[idx_q - IW'(PAR_FIRST)];
    else if (idx_q < IW'(LAST_BIT))
      cur_bit = crc_q[IW'(CRC_BITS - 1) - (idx_q - IW'(CRC_FIRST))];
    else
      cur_bit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q  <= '0;
      par_q  <= '0;
      adr_q  <= '0;
      crc_q  <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        dat_q  <= dat_w;
        par_q  <= parity_i;
        adr_q  <= addr_i;
        crc_q  <= '0;
        idx_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (bit_end) begin
        cnt_q <= '0;
        if (in_pay)
          crc_q <= {crc_q[CRC_BITS-2:0], 1'b0} ^ (crc_fb ? POLY : '0);
        if (idx_q == IW'(LAST_BIT)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else if (busy_q && tick_en) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign pulse_o = busy_q && cur_bit && (cnt_q < CW'(PULSE_TICKS));

  a_r5_pulse_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> busy_o);

  a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> ($stable(adr_q) && $stable(dat_q) && $stable(par_q)));

  a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tick_en && !start_i) |=> ($stable(cnt_q) && $stable(idx_q) && busy_o));

  a_r2_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (idx_q <= IW'(LAST_BIT)));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt_q < period));
endmodule

// File: tb/test_crc5_pulse_framer.sv
module test_crc5_pulse_framer;
  localparam int P  = 2;
  localparam int T0 = 8, T1 = 6, T2 = 5, T3 = 4;
  localparam int NB = 46;
  localparam int NV = 5;
  // entry: {addr[1:0], channel[1:0], pressure[13:0], parity[15:0]}
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 2'd2, 14'h2A5C, 16'hBEEF},
    {2'd1, 2'd1, 14'h1357, 16'h0F0F},
    {2'd2, 2'd3, 14'h3FFF, 16'hFFFF},
    {2'd3, 2'd0, 14'h0000, 16'h0000},
    {2'd3, 2'd2, 14'h0ACE, 16'h8001}
  };

  logic clk = 0, rst_n = 0, tick_en = 1, start_i = 0;
  logic [13:0] pressure_i = '0;
  logic [1:0]  channel_i = '0, addr_i = '0;
  logic [15:0] parity_i = '0;
  logic busy_o, done_o, pulse_o;
  int checks = 0, fails = 0;
  logic half_rate = 0;
  logic [NB-1:0] fr;

  always #4 clk = ~clk;
  always @(negedge clk) tick_en <= half_rate ? ~tick_en : 1'b1;

  crc5_pulse_framer #(.PULSE_TICKS(P), .BIT_TICKS_A0(T0), .BIT_TICKS_A1(T1),
                      .BIT_TICKS_A2(T2), .BIT_TICKS_A3(T3)) i_crc5_pulse_framer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start_i(start_i),
    .pressure_i(pressure_i), .channel_i(channel_i), .parity_i(parity_i),
    .addr_i(addr_i), .busy_o(busy_o), .done_o(done_o), .pulse_o(pulse_o));

  function automatic int per_of(input logic [1:0] a);
    return (a == 0) ? T0 : (a == 1) ? T1 : (a == 2) ? T2 : T3;
  endfunction

  // fr[i] is frame bit i in sending order (R2, R3, R4)
  function automatic logic [NB-1:0] build(input logic [1:0] a, input logic [1:0] ch,
                                          input logic [13:0] pr, input logic [15:0] pa);
    logic [NB-1:0] f;
    logic [4:0] c;
    f = '0;
    for (int i = 0; i < 4; i++) f[i] = 1'b1;
    f[4] = a[0]; f[5] = a[1];
    for (int i = 0; i < 14; i++) f[6+i] = pr[i];
    f[20] = ch[0]; f[21] = ch[1]; f[22] = a[0]; f[23] = a[1];
    for (int i = 0; i < 16; i++) f[24+i] = pa[i];
    c = '0;
    for (int i = 4; i < 40; i++) begin
      logic m;
      m = c[4] ^ f[i];
      c = {c[3:0], 1'b0};
      if (m) c = c ^ 5'b00101;
    end
    for (int i = 0; i < 5; i++) f[40+i] = c[4-i];
    f[45] = 1'b1;
    return f;
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [33:0] v, input bit inject);
    int per, bad, bad_k;
    logic got, want;
    {addr_i, channel_i, pressure_i, parity_i} = v;
    per = per_of(v[33:32]);
    fr = build(v[33:32], v[31:30], v[29:16], v[15:0]);
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    bad = 0; bad_k = -1; got = 0; want = 0;
    for (int k = 0; k < NB * per; k++) begin
      logic e;
      e = fr[k / per] && ((k % per) < P);
      if ((pulse_o !== e || busy_o !== 1'b1) && bad == 0) begin
        bad = 1; bad_k = k; got = pulse_o; want = e;
      end
      if (inject && k == 30) begin
        {addr_i, channel_i, pressure_i, parity_i} = ~v;
        start_i = 1;
      end else begin
        start_i = 0;
      end
      @(negedge clk);
    end
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s frame addr=%0d cycle %0d actual=%0b expected=%0b",
               inject ? "R9" : "R2/R3/R4/R5/R6", v[33:32], bad_k, got, want);
    end
    check("R8", busy_o, 1'b0, "busy after stop bit");
    check("R8", done_o, 1'b1, "done at frame end");
    @(negedge clk);
    check("R8", done_o, 1'b0, "done one cycle only");
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", busy_o, 1'b0, "busy in reset");
    check("R1", pulse_o, 1'b0, "pulse in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1", done_o, 1'b0, "done after reset");
    check("R1", busy_o, 1'b0, "busy after reset");

    for (int i = 0; i < NV; i++) run_frame(VEC[i], 1'b0);

    // R4: CRC of a known pattern must be non-zero for a non-zero payload
    fr = build(2'd0, 2'd0, 14'h0001, 16'h0000);
    check("R4", |fr[44:40], 1'b1, "crc nonzero for single one");

    // R9: start during a frame
    run_frame(VEC[1], 1'b1);

    // R7: half-rate time base doubles the frame length
    begin
      int n, per;
      half_rate = 1;
      {addr_i, channel_i, pressure_i, parity_i} = VEC[3];
      per = per_of(VEC[3][33:32]);
      @(negedge clk) start_i = 1;
      @(negedge clk) start_i = 0;
      n = 0;
      while (busy_o === 1'b1 && n < 10000) begin
        n++;
        @(negedge clk);
      end
      checks++;
      if (n < 2*NB*per - 2 || n > 2*NB*per + 2) begin
        fails++;
        $display("FAIL R7 busy length actual=%0d expected=%0d", n, 2*NB*per);
      end
      half_rate = 0;
      repeat (3) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule